// File: doc/BRIEF.md
# Two-Channel Remappable Interrupt Router

This block gathers a set of asynchronous external interrupt lines and steers them onto two active-low request lines of a processor: a fast request line and a normal request line. The fast line is the one the processor services first. The normal channel has 20 logical interrupt sources and the fast channel has 4. The two channels work the same way but are configured and cleared separately.

Every logical source has its own configuration word. The word picks one of the physical inputs, so any source can listen to any input and several sources can share one input. It also picks level or edge triggering, picks the polarity, and enables or disables the source. Software configures the sources and reads or clears the pending state through a small synchronous register port. Physical inputs go through a two-flop synchronizer before any edge or level is evaluated.

Top module: `dual_chan_intc`

## Requirements
- R1: After reset both request outputs are high, all pending bits are 0 and every configuration word reads 0.
- R2: A change on a physical input reaches the pending state at the third rising clock edge after the change: two synchronizer flops and then the pending register.
- R3: The configuration word of normal source k is at address k (0 to 19). The word of fast source j is at address 20+j. Bits [3:0] select the physical input, bit 8 selects edge mode (1) or level mode (0), bit 9 selects active-low (1) or active-high (0), and bit 10 is the enable. All other bits read 0.
- R4: Any source can select any physical input. Two or more sources that select the same input each react to it, and this holds across both channels.
- R5: In level mode the pending bit follows the qualified input level, one clock after it is synchronized. A write-1 clear has no effect on it.
- R6: In edge mode a rising edge (active-high) or a falling edge (active-low) sets the pending bit, and the bit stays set until a 1 is written to its position. Normal pending is at address 32 (bit k) and fast pending is at address 34 (bit j). An edge and a clear in the same cycle leave the bit set.
- R7: Pending bits are recorded whether or not the source is enabled. The status registers return pending AND enable: normal at address 33 and fast at address 35.
- R8: `n_irq_o` is low exactly when normal status is nonzero. `n_fiq_o` is low exactly when fast status is nonzero. Neither channel affects the other.
- R9: Unmapped addresses read 0. Writes to the status addresses and to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phys_irq_i | input | N_PHYS | Asynchronous physical interrupt inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational from address) |
| n_fiq_o | output | 1 | Active-low fast channel request |
| n_irq_o | output | 1 | Active-low normal channel request |

## Verification
A corrupted pending bit appears on the matching request output in the same cycle and in the pending and status readback. A dropped or doubled synchronizer stage shifts the R2 timing by one cycle, and the cycle-exact comparison catches that at the first input change. A wrong select, polarity or mode field shows up as a pending bit that rises on the wrong input or edge, or that is cleared when it should not be. The reference model flags it at the first clock where the pending or status readback differs. Cross-channel leakage appears as a request output that moves while only the other channel has status.

// File: rtl/dcintc_pkg.sv
package dcintc_pkg;
   // Trigger settings of one logical source
   typedef struct packed {
      logic en;
      logic act_low;
      logic edge_md;
   } trig_cfg_t;

   // Field positions inside a configuration word
   localparam int CFG_EDGE_BIT = 8;
   localparam int CFG_LOW_BIT  = 9;
   localparam int CFG_EN_BIT   = 10;
   localparam int CFG_MIN_W    = CFG_EN_BIT + 1;
endpackage

// File: rtl/dcintc_sync.sv
module dcintc_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] cur_o,
   output logic [WIDTH-1:0] prev_o
);
   // chain[STAGES-1] is the synchronized value, chain[STAGES] is its previous sample
   logic [STAGES:0][WIDTH-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dcintc_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], raw_i};
   end

   assign cur_o  = chain[STAGES-1];
   assign prev_o = chain[STAGES];
endmodule

// File: rtl/dcintc_source.sv
module dcintc_source
   import dcintc_pkg::*;
#(
   parameter int N_PHYS = 16,
   parameter int SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  sel_i,
   input  trig_cfg_t         cfg_i,
   input  logic [N_PHYS-1:0] cur_i,
   input  logic [N_PHYS-1:0] prev_i,
   input  logic              clr_i,
   output logic              pend_o
);
   logic cur_b, prev_b, lvl_hit, edge_hit, pend_q, pend_d;

   assign cur_b    = cur_i[sel_i];
   assign prev_b   = prev_i[sel_i];
   assign lvl_hit  = cur_b ^ cfg_i.act_low;
   assign edge_hit = cfg_i.act_low ? (prev_b & ~cur_b) : (cur_b & ~prev_b);

   // Edge mode: the set wins over a clear in the same cycle. Level mode: follow the input.
   assign pend_d = cfg_i.edge_md ? (edge_hit | (pend_q & ~clr_i)) : lvl_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
   end

   assign pend_o = pend_q;

   // R5
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_i.edge_md && lvl_hit) |=> pend_q);
   // R6
   edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i.edge_md && edge_hit) |=> pend_q);
   // R6
   edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i.edge_md && pend_q && !clr_i) |=> pend_q);
   // R6
   edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i.edge_md && clr_i && !edge_hit) |=> !pend_q);
endmodule

// File: rtl/dcintc_channel.sv
module dcintc_channel
   import dcintc_pkg::*;
#(
   parameter int N_SRC  = 20,
   parameter int N_PHYS = 16,
   parameter int SEL_W  = 4,
   parameter int DATA_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_SRC-1:0]             cfg_we_i,
   input  logic                         clr_we_i,
   input  logic [DATA_W-1:0]            wdata_i,
   input  logic [N_PHYS-1:0]            cur_i,
   input  logic [N_PHYS-1:0]            prev_i,
   output logic [N_SRC-1:0][DATA_W-1:0] ctrl_rd_o,
   output logic [N_SRC-1:0]             pend_o,
   output logic [N_SRC-1:0]             stat_o,
   output logic                         req_n_o
);
   logic [N_SRC-1:0][SEL_W-1:0] sel_q;
   trig_cfg_t [N_SRC-1:0]       cfg_q;
   logic [N_SRC-1:0]            en_vec;
   logic                        unused_wdata;

   assign unused_wdata = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         cfg_q <= '0;
      end else begin
         for (int k = 0; k < N_SRC; k++) begin
            if (cfg_we_i[k]) begin
               sel_q[k]         <= wdata_i[SEL_W-1:0];
               cfg_q[k].edge_md <= wdata_i[CFG_EDGE_BIT];
               cfg_q[k].act_low <= wdata_i[CFG_LOW_BIT];
               cfg_q[k].en      <= wdata_i[CFG_EN_BIT];
            end
         end
      end
   end

   always_comb begin
      ctrl_rd_o = '0;
      for (int k = 0; k < N_SRC; k++) begin
         ctrl_rd_o[k][SEL_W-1:0]    = sel_q[k];
         ctrl_rd_o[k][CFG_EDGE_BIT] = cfg_q[k].edge_md;
         ctrl_rd_o[k][CFG_LOW_BIT]  = cfg_q[k].act_low;
         ctrl_rd_o[k][CFG_EN_BIT]   = cfg_q[k].en;
         en_vec[k]                  = cfg_q[k].en;
      end
   end

   genvar g;
   generate
      for (g = 0; g < N_SRC; g++) begin : g_src
         dcintc_source #(
            .N_PHYS (N_PHYS),
            .SEL_W  (SEL_W)
         ) u_src (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel_i  (sel_q[g]),
            .cfg_i  (cfg_q[g]),
            .cur_i  (cur_i),
            .prev_i (prev_i),
            .clr_i  (clr_we_i & wdata_i[g]),
            .pend_o (pend_o[g])
         );
      end
   endgenerate

   assign stat_o  = pend_o & en_vec;
   assign req_n_o = ~|stat_o;
endmodule

// File: rtl/dual_chan_intc.sv
module dual_chan_intc
   import dcintc_pkg::*;
#(
   parameter int N_PHYS      = 16,
   parameter int N_NORM      = 20,
   parameter int N_FAST      = 4,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PHYS-1:0] phys_irq_i,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              n_fiq_o,
   output logic              n_irq_o
);
   localparam int SEL_W    = (N_PHYS > 1) ? $clog2(N_PHYS) : 1;
   localparam int N_LOG    = N_NORM + N_FAST;
   localparam int REG_BASE = 1 << (ADDR_W - 1);
   localparam logic [ADDR_W-1:0] A_PEND_N = ADDR_W'(REG_BASE);
   localparam logic [ADDR_W-1:0] A_STAT_N = ADDR_W'(REG_BASE + 1);
   localparam logic [ADDR_W-1:0] A_PEND_F = ADDR_W'(REG_BASE + 2);
   localparam logic [ADDR_W-1:0] A_STAT_F = ADDR_W'(REG_BASE + 3);

   generate
      if (N_PHYS < 2 || (1 << SEL_W) != N_PHYS) begin : g_bad_phys
         $error("dual_chan_intc: N_PHYS must be a power of two, at least 2");
      end
      if (SEL_W > CFG_EDGE_BIT) begin : g_bad_sel
         $error("dual_chan_intc: select field overlaps the mode bits");
      end
      if (N_NORM < 1 || N_FAST < 1 || N_NORM > DATA_W || N_FAST > DATA_W) begin : g_bad_cnt
         $error("dual_chan_intc: source counts must fit the data width");
      end
      if (DATA_W < CFG_MIN_W) begin : g_bad_dw
         $error("dual_chan_intc: DATA_W too small for the configuration word");
      end
      if (N_LOG > REG_BASE) begin : g_bad_aw
         $error("dual_chan_intc: ADDR_W too small for the configuration words");
      end
   endgenerate

   logic [N_PHYS-1:0]             sync_cur, sync_prev;
   logic [N_NORM-1:0]             norm_cfg_we, norm_pend, norm_stat;
   logic [N_FAST-1:0]             fast_cfg_we, fast_pend, fast_stat;
   logic [N_NORM-1:0][DATA_W-1:0] norm_ctrl;
   logic [N_FAST-1:0][DATA_W-1:0] fast_ctrl;
   logic                          norm_clr_we, fast_clr_we;

   dcintc_sync #(
      .WIDTH  (N_PHYS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (phys_irq_i),
      .cur_o  (sync_cur),
      .prev_o (sync_prev)
   );

   always_comb begin
      for (int k = 0; k < N_NORM; k++)
         norm_cfg_we[k] = reg_we_i && (reg_addr_i == ADDR_W'(k));
      for (int j = 0; j < N_FAST; j++)
         fast_cfg_we[j] = reg_we_i && (reg_addr_i == ADDR_W'(N_NORM + j));
   end

   assign norm_clr_we = reg_we_i && (reg_addr_i == A_PEND_N);
   assign fast_clr_we = reg_we_i && (reg_addr_i == A_PEND_F);

   dcintc_channel #(
      .N_SRC  (N_NORM),
      .N_PHYS (N_PHYS),
      .SEL_W  (SEL_W),
      .DATA_W (DATA_W)
   ) u_norm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we_i  (norm_cfg_we),
      .clr_we_i  (norm_clr_we),
      .wdata_i   (reg_wdata_i),
      .cur_i     (sync_cur),
      .prev_i    (sync_prev),
      .ctrl_rd_o (norm_ctrl),
      .pend_o    (norm_pend),
      .stat_o    (norm_stat),
      .req_n_o   (n_irq_o)
   );

   dcintc_channel #(
      .N_SRC  (N_FAST),
      .N_PHYS (N_PHYS),
      .SEL_W  (SEL_W),
      .DATA_W (DATA_W)
   ) u_fast (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we_i  (fast_cfg_we),
      .clr_we_i  (fast_clr_we),
      .wdata_i   (reg_wdata_i),
      .cur_i     (sync_cur),
      .prev_i    (sync_prev),
      .ctrl_rd_o (fast_ctrl),
      .pend_o    (fast_pend),
      .stat_o    (fast_stat),
      .req_n_o   (n_fiq_o)
   );

   always_comb begin
      reg_rdata_o = '0;
      for (int k = 0; k < N_NORM; k++)
         if (reg_addr_i == ADDR_W'(k)) reg_rdata_o = norm_ctrl[k];
      for (int j = 0; j < N_FAST; j++)
         if (reg_addr_i == ADDR_W'(N_NORM + j)) reg_rdata_o = fast_ctrl[j];
      if (reg_addr_i == A_PEND_N) reg_rdata_o = DATA_W'(norm_pend);
      if (reg_addr_i == A_STAT_N) reg_rdata_o = DATA_W'(norm_stat);
      if (reg_addr_i == A_PEND_F) reg_rdata_o = DATA_W'(fast_pend);
      if (reg_addr_i == A_STAT_F) reg_rdata_o = DATA_W'(fast_stat);
   end

   // R8
   chan_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|fast_stat) && !(|norm_stat)) |-> (!n_fiq_o && n_irq_o));
   // R8
   chan_split_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|norm_stat) && !(|fast_stat)) |-> (!n_irq_o && n_fiq_o));
endmodule

// File: tb/dual_chan_intc_bench.sv
module dual_chan_intc_bench;
   localparam int NP = 16, NN = 20, NF = 4, DW = 32, AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] phys = '0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          n_fiq, n_irq;

   int n_chk = 0, n_fail = 0, peek_idx = 0;
   bit done = 0;

   // reference model state
   int      m_sel [NN+NF];
   bit      m_edge[NN+NF], m_low[NN+NF], m_en[NN+NF], m_pend[NN+NF];
   bit [NP-1:0] m_s1, m_cur, m_prev;

   always #10 clk = ~clk;

   dual_chan_intc #(.N_PHYS(NP), .N_NORM(NN), .N_FAST(NF), .DATA_W(DW), .ADDR_W(AW)) u_dual_chan_intc (
      .clk(clk), .rst_n(rst_n), .phys_irq_i(phys), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .n_fiq_o(n_fiq), .n_irq_o(n_irq));

   task automatic model_step();
      bit np[NN+NF];
      for (int k = 0; k < NN+NF; k++) begin
         bit s, p, hit, clr;
         int b;
         b = (k >= NN) ? k - NN : k;
         s = m_cur[m_sel[k]];
         p = m_prev[m_sel[k]];
         clr = reg_we && (reg_addr == ((k >= NN) ? 34 : 32)) && reg_wdata[b];
         if (m_edge[k]) begin
            hit = m_low[k] ? (p && !s) : (s && !p);
            np[k] = hit || (m_pend[k] && !clr);
         end else np[k] = s ^ m_low[k];
      end
      for (int k = 0; k < NN+NF; k++) m_pend[k] = np[k];
      if (reg_we && reg_addr < NN+NF) begin
         m_sel [reg_addr] = reg_wdata[3:0];
         m_edge[reg_addr] = reg_wdata[8];
         m_low [reg_addr] = reg_wdata[9];
         m_en  [reg_addr] = reg_wdata[10];
      end
      m_prev = m_cur;
      m_cur  = m_s1;
      m_s1   = phys;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NN+NF; k++) begin
            m_sel[k] = 0; m_edge[k] = 0; m_low[k] = 0; m_en[k] = 0; m_pend[k] = 0;
         end
         m_s1 = '0; m_cur = '0; m_prev = '0;
      end else model_step();
   end

   function automatic bit [DW-1:0] exp_read(int a);
      bit [DW-1:0] v = '0;
      if (a < NN+NF) begin
         v = DW'(m_sel[a]);
         v[8] = m_edge[a]; v[9] = m_low[a]; v[10] = m_en[a];
      end else if (a == 32 || a == 33) begin
         for (int k = 0; k < NN; k++) v[k] = m_pend[k] && (a == 32 || m_en[k]);
      end else if (a == 34 || a == 35) begin
         for (int j = 0; j < NF; j++) v[j] = m_pend[NN+j] && (a == 34 || m_en[NN+j]);
      end
      return v;
   endfunction

   function automatic bit exp_req_n(bit fast);
      bit any = 0;
      for (int k = 0; k < NN+NF; k++)
         if ((k >= NN) == fast && m_pend[k] && m_en[k]) any = 1;
      return !any;
   endfunction

   task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic peek(int a, output logic [DW-1:0] v);
      reg_addr = AW'(a);
      #1 v = reg_rdata;
   endtask

   task automatic compare_model();
      logic [DW-1:0] v;
      check("R8 n_irq", DW'(n_irq), DW'(exp_req_n(0)));
      check("R8 n_fiq", DW'(n_fiq), DW'(exp_req_n(1)));
      peek(32, v); check("R5 normal pending", v, exp_read(32));
      peek(33, v); check("R7 normal status", v, exp_read(33));
      peek(34, v); check("R6 fast pending", v, exp_read(34));
      peek(35, v); check("R7 fast status", v, exp_read(35));
      peek(peek_idx, v); check("R3 config word", v, exp_read(peek_idx));
      peek(40 + peek_idx % 20, v); check("R9 unmapped", v, '0);
      peek_idx = (peek_idx + 1) % (NN+NF);
   endtask

   task automatic tick();
      @(negedge clk);
      reg_we = 1'b0;
      if (rst_n) compare_model();
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic wr(int a, logic [DW-1:0] d);
      reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      tick();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [DW-1:0] v;
      ticks(3);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      check("R1 n_irq", DW'(n_irq), 1);
      check("R1 n_fiq", DW'(n_fiq), 1);
      peek(32, v); check("R1 normal pending", v, 0);
      peek(34, v); check("R1 fast pending", v, 0);
      peek(5, v);  check("R1 config", v, 0);

      // R2 latency with a level high source on input 3
      wr(0, 32'h403);
      phys[3] = 1'b1;
      ticks(2);
      peek(32, v); check("R2 not yet pending", v & 1, 0);
      tick();
      peek(32, v); check("R2 pending at third edge", v & 1, 1);
      check("R8 n_irq low", DW'(n_irq), 0);
      wr(32, 1);
      peek(32, v); check("R5 clear ignored while asserted", v & 1, 1);
      phys[3] = 1'b0;
      ticks(3);
      peek(32, v); check("R5 follows level off", v & 1, 0);
      check("R8 n_irq high", DW'(n_irq), 1);

      // R4 shared input across channels, R7 disabled source
      wr(20, 32'h503);
      wr(1, 32'h103);
      phys[3] = 1'b1;
      ticks(3);
      peek(34, v); check("R4 fast shares input", v & 1, 1);
      peek(32, v); check("R4 normal shares input", v, 3);
      peek(33, v); check("R7 status masks disabled", v, 1);
      phys[3] = 1'b0;
      ticks(3);
      peek(32, v); check("R6 edge stays pending", v, 2);
      peek(33, v); check("R7 disabled status clear", v, 0);
      check("R7 disabled pending no request", DW'(n_irq), 1);
      check("R6 fast request held", DW'(n_fiq), 0);
      wr(34, 1);
      peek(34, v); check("R6 write-1 clear", v, 0);
      check("R6 fast request released", DW'(n_fiq), 1);

      // R6 falling edge source on input 5
      wr(21, 32'h705);
      phys[5] = 1'b1;
      ticks(4);
      peek(34, v); check("R6 rising ignored for active-low", v, 0);
      phys[5] = 1'b0;
      ticks(3);
      peek(34, v); check("R6 falling edge sets", v, 2);
      phys[5] = 1'b1;
      ticks(3);
      wr(34, 2);
      peek(34, v); check("R6 cleared", v, 0);
      phys[5] = 1'b0;
      ticks(2);
      wr(34, 2);
      peek(34, v); check("R6 set wins over clear", v, 2);

      // R5 active-low level on the last normal source
      wr(19, 32'h60F);
      tick();
      peek(32, v); check("R5 active-low level", (v >> 19) & 1, 1);
      phys[15] = 1'b1;
      ticks(3);
      peek(32, v); check("R5 active-low released", (v >> 19) & 1, 0);

      // R9 ignored writes
      wr(33, 32'hFFFF_FFFF);
      wr(40, 32'hFFFF_FFFF);
      peek(40, v); check("R9 unmapped read", v, 0);
      peek(3, v);  check("R9 no side effect", v, 0);

      // mixed traffic against the model
      for (int c = 0; c < 3000; c++) begin
         int r;
         r = $urandom % 12;
         if ($urandom % 3 == 0) phys[$urandom % NP] ^= 1'b1;
         if (r == 0)      wr($urandom % (NN+NF), $urandom);
         else if (r == 1) wr(32, $urandom);
         else if (r == 2) wr(34, $urandom);
         else if (r == 3) wr(33 + 2 * ($urandom % 2), $urandom);
         else             tick();
      end
      finish_run();
   end
endmodule